// File: doc/BRIEF.md
# ADC Interrupt Flag Register File

This block gathers interrupt events produced by an analog-to-digital converter and turns them into one interrupt request for the interrupt controller. Two kinds of event are kept. The first is a per-channel end-of-conversion event, held in a pending vector and gated by a per-channel enable vector. The second is a set of analog watchdog events, held in one status byte. That byte carries a low-threshold flag and a high-threshold flag for each of four monitored channels. A mask byte gates it bit for bit.

Event pulses arrive on input pins, one cycle wide. Each pulse sets its flag on the next clock edge. Software reads the registers through a combinational read port. It changes the registers through a single-cycle write port with no handshake. Status registers clear when written with 1. Enable and mask registers are plain read/write. Threshold comparison, conversion sequencing and the bus fabric sit outside the block.

Top module: `adc_irq_flags`

## Requirements
- R1: After reset, every pending flag, enable bit and mask bit is 0, and `irq` is 0.
- R2: A 1 on `eoc_evt[n]` at a clock edge sets bit n of the end-of-conversion pending register (address 0), and the bit reads back as 1 from the next cycle on.
- R3: Watchdog events land in the status register (address 2) by a fixed layout. `wdg_lo_evt[n]` sets bit 2n and `wdg_hi_evt[n]` sets bit 2n+1, for n from 0 to 3. Bits 8 and up of that register read as 0.
- R4: A write to address 0 or address 2 clears each flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R5: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R6: `irq` is 1 exactly when some watchdog status bit and its mask bit (address 3, same layout as R3) are both 1, or some end-of-conversion pending bit and its enable bit (address 1) are both 1. `irq` follows the registers with no extra delay.
- R7: The enable register (address 1) and the mask register (address 3) take the written data and read it back unchanged. For the mask register this is the low 8 bits, with the upper bits reading 0.
- R8: Reads have no side effect. A read of any address leaves every register unchanged.
- R9: Status registers are never set by a write. Writes to addresses 4 to 7 change nothing, and reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eoc_evt | input | NUM_CH | End-of-conversion event pulses, one per channel |
| wdg_hi_evt | input | NUM_WDG | High-threshold violation pulses, one per monitored channel |
| wdg_lo_evt | input | NUM_WDG | Low-threshold violation pulses, one per monitored channel |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 3 | Write register address |
| wr_data | input | DW | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | DW | Combinational read data |
| irq | output | 1 | Interrupt request to the controller |

## Verification
Each of the eight watchdog bits is raised alone and then swept through all 256 mask values. This separates a wrong bit placement, meaning a swapped high/low pair or a wrong channel, from a wrong gating term. Each end-of-conversion channel is raised alone, with its enable off and then on. It is then written with 0 and with a one-hot 1, which separates a correct clear from a clear that is too wide or that ignores the data. Same-cycle set/clear collisions, writes to unused addresses and a long run of random events and writes, all checked against an arithmetic model, expose any ordering fault between set and clear.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    A_EOC_PEND = 3'd0,
    A_EOC_EN   = 3'd1,
    A_WDG_STAT = 3'd2,
    A_WDG_MASK = 3'd3
  } reg_addr_e;
endpackage

// File: rtl/adc_irq_w1c_bank.sv
// Bank of sticky flags: set by event pulses, cleared by write-one; set wins.
module adc_irq_w1c_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/adc_irq_ctl_reg.sv
// Plain read/write control register (enables or mask).
module adc_irq_ctl_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (we_i) q <= wdata_i;
  end

  assign q_o = q;
endmodule

// File: rtl/adc_irq_req_merge.sv
// Gates each flag with its enable and reduces both groups to one request.
module adc_irq_req_merge #(
  parameter int NCH  = 16,
  parameter int WDGW = 8
) (
  input  logic [NCH-1:0]  eoc_flags_i,
  input  logic [NCH-1:0]  eoc_en_i,
  input  logic [WDGW-1:0] wdg_flags_i,
  input  logic [WDGW-1:0] wdg_mask_i,
  output logic            irq_o
);
  logic [NCH-1:0]  eoc_hit;
  logic [WDGW-1:0] wdg_hit;

  for (genvar i = 0; i < NCH; i++) begin : g_eoc
    assign eoc_hit[i] = eoc_flags_i[i] & eoc_en_i[i];
  end
  for (genvar j = 0; j < WDGW; j++) begin : g_wdg
    assign wdg_hit[j] = wdg_flags_i[j] & wdg_mask_i[j];
  end

  assign irq_o = (|eoc_hit) | (|wdg_hit);
endmodule

// File: rtl/adc_irq_flags.sv
module adc_irq_flags
  import adc_irq_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int NUM_WDG = 4,
  parameter int DW      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] eoc_evt,
  input  logic [NUM_WDG-1:0] wdg_hi_evt,
  input  logic [NUM_WDG-1:0] wdg_lo_evt,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              irq
);
  localparam int WDG_W = 2 * NUM_WDG;

  logic [NUM_CH-1:0] eoc_q, en_q, eoc_clr;
  logic [WDG_W-1:0]  wdg_q, msk_q, wdg_clr, wdg_set;
  logic              we_en, we_msk;

  // Pair layout: low threshold at even bit, high threshold at odd bit.
  for (genvar n = 0; n < NUM_WDG; n++) begin : g_pack
    assign wdg_set[2*n]   = wdg_lo_evt[n];
    assign wdg_set[2*n+1] = wdg_hi_evt[n];
  end

  assign eoc_clr = (wr_en && wr_addr == A_EOC_PEND) ? wr_data[NUM_CH-1:0] : '0;
  assign wdg_clr = (wr_en && wr_addr == A_WDG_STAT) ? wr_data[WDG_W-1:0]  : '0;
  assign we_en   = wr_en && (wr_addr == A_EOC_EN);
  assign we_msk  = wr_en && (wr_addr == A_WDG_MASK);

  adc_irq_w1c_bank #(.W(NUM_CH)) u_eoc (
    .clk(clk), .rst_n(rst_n), .set_i(eoc_evt), .clr_i(eoc_clr), .flags_o(eoc_q));

  adc_irq_w1c_bank #(.W(WDG_W)) u_wdg (
    .clk(clk), .rst_n(rst_n), .set_i(wdg_set), .clr_i(wdg_clr), .flags_o(wdg_q));

  adc_irq_ctl_reg #(.W(NUM_CH)) u_en (
    .clk(clk), .rst_n(rst_n), .we_i(we_en), .wdata_i(wr_data[NUM_CH-1:0]), .q_o(en_q));

  adc_irq_ctl_reg #(.W(WDG_W)) u_msk (
    .clk(clk), .rst_n(rst_n), .we_i(we_msk), .wdata_i(wr_data[WDG_W-1:0]), .q_o(msk_q));

  adc_irq_req_merge #(.NCH(NUM_CH), .WDGW(WDG_W)) u_merge (
    .eoc_flags_i(eoc_q), .eoc_en_i(en_q),
    .wdg_flags_i(wdg_q), .wdg_mask_i(msk_q), .irq_o(irq));

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_EOC_PEND: rd_data[NUM_CH-1:0] = eoc_q;
      A_EOC_EN:   rd_data[NUM_CH-1:0] = en_q;
      A_WDG_STAT: rd_data[WDG_W-1:0]  = wdg_q;
      A_WDG_MASK: rd_data[WDG_W-1:0]  = msk_q;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/adc_irq_flags_chk.sv
module adc_irq_flags_chk #(
  parameter int NUM_CH  = 16,
  parameter int NUM_WDG = 4,
  parameter int DW      = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CH-1:0]    eoc_evt,
  input logic [NUM_WDG-1:0]   wdg_hi_evt,
  input logic [NUM_WDG-1:0]   wdg_lo_evt,
  input logic                 wr_en,
  input logic [2:0]           wr_addr,
  input logic [DW-1:0]        wr_data,
  input logic                 irq,
  input logic [NUM_CH-1:0]    eoc_q,
  input logic [NUM_CH-1:0]    en_q,
  input logic [2*NUM_WDG-1:0] wdg_q,
  input logic [2*NUM_WDG-1:0] msk_q
);
  // R1: reset empties every register
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (eoc_q == '0 && wdg_q == '0 && en_q == '0 && msk_q == '0));

  // R2: an end-of-conversion pulse is captured
  p_eoc_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_evt != '0) |=> ((eoc_q & $past(eoc_evt)) == $past(eoc_evt)));

  // R3: bit layout of the watchdog byte
  for (genvar n = 0; n < NUM_WDG; n++) begin : g_lay
    p_lo_layout_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wdg_lo_evt[n] |=> wdg_q[2*n]);
    p_hi_layout_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wdg_hi_evt[n] |=> wdg_q[2*n+1]);
  end

  // R4: write-one clears without a competing event
  p_w1c_eoc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0 && eoc_evt == '0)
      |=> ((eoc_q & $past(wr_data[NUM_CH-1:0])) == '0));

  // R9: flags never rise without an event
  p_no_spont_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((eoc_q & ~$past(eoc_q) & ~$past(eoc_evt)) == '0));

  // R6: request follows gated flags
  p_irq_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (((wdg_q & msk_q) != '0) || ((eoc_q & en_q) != '0)) |-> irq);
  p_irq_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wdg_q == '0 && eoc_q == '0) |-> !irq);
endmodule

bind adc_irq_flags adc_irq_flags_chk #(.NUM_CH(NUM_CH), .NUM_WDG(NUM_WDG), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .eoc_evt(eoc_evt), .wdg_hi_evt(wdg_hi_evt),
  .wdg_lo_evt(wdg_lo_evt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .irq(irq), .eoc_q(eoc_q), .en_q(en_q), .wdg_q(wdg_q), .msk_q(msk_q));

// File: tb/sim_adc_irq_flags.sv
`timescale 1ns/1ps
module sim_adc_irq_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] eoc_evt = '0;
  logic [3:0]  wdg_hi_evt = '0, wdg_lo_evt = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;

  int vectors = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_eoc = '0, m_en = '0;
  logic [7:0]  m_wdg = '0, m_msk = '0;

  always #5 clk = ~clk;

  adc_irq_flags u0 (
    .clk(clk), .rst_n(rst_n), .eoc_evt(eoc_evt), .wdg_hi_evt(wdg_hi_evt),
    .wdg_lo_evt(wdg_lo_evt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  function automatic logic [15:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_eoc;
      3'd1: return m_en;
      3'd2: return {8'h00, m_wdg};
      3'd3: return {8'h00, m_msk};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [7:0] pack_wdg(input logic [3:0] hi, input logic [3:0] lo);
    logic [7:0] v;
    for (int n = 0; n < 4; n++) begin
      v[2*n]   = lo[n];
      v[2*n+1] = hi[n];
    end
    return v;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_irq(input string req);
    chk(req, {15'd0, irq}, {15'd0, ((m_wdg & m_msk) != 0) || ((m_eoc & m_en) != 0)});
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < 8; a++) begin
      rd_addr = a[2:0];
      #1;
      chk(req, rd_data, exp_rd(a[2:0]));
    end
    check_irq(req);
  endtask

  // Drive one cycle of stimulus at the falling edge; update the model at the rising edge.
  task automatic step(input logic [15:0] e, input logic [3:0] hi, input logic [3:0] lo,
                      input logic we, input logic [2:0] a, input logic [15:0] d);
    eoc_evt = e; wdg_hi_evt = hi; wdg_lo_evt = lo;
    wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    if (we && a == 3'd0) m_eoc = m_eoc & ~d;
    if (we && a == 3'd2) m_wdg = m_wdg & ~d[7:0];
    if (we && a == 3'd1) m_en  = d;
    if (we && a == 3'd3) m_msk = d[7:0];
    m_eoc = m_eoc | e;
    m_wdg = m_wdg | pack_wdg(hi, lo);
    @(negedge clk);
    eoc_evt = '0; wdg_hi_evt = '0; wdg_lo_evt = '0; wr_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2 / R4 / R6: each end-of-conversion channel alone
    for (int c = 0; c < 16; c++) begin
      step(16'(1 << c), 4'h0, 4'h0, 1'b0, 3'd0, 16'h0);
      check_all("R2");
      step('0, 4'h0, 4'h0, 1'b1, 3'd1, 16'(1 << c));
      check_all("R6");
      step('0, 4'h0, 4'h0, 1'b1, 3'd0, 16'h0000);
      check_all("R4");
      step('0, 4'h0, 4'h0, 1'b1, 3'd0, 16'(1 << c));
      check_all("R4");
      step('0, 4'h0, 4'h0, 1'b1, 3'd1, 16'h0000);
    end

    // R3 / R6 / R7: each watchdog bit alone, all mask values
    for (int b = 0; b < 8; b++) begin
      step('0, (b % 2 == 1) ? 4'(1 << (b / 2)) : 4'h0,
               (b % 2 == 0) ? 4'(1 << (b / 2)) : 4'h0, 1'b0, 3'd0, 16'h0);
      check_all("R3");
      for (int m = 0; m < 256; m++) begin
        step('0, 4'h0, 4'h0, 1'b1, 3'd3, 16'hAB00 | 16'(m));
        check_irq("R6");
        rd_addr = 3'd3; #1;
        chk("R7", rd_data, 16'(m));
      end
      step('0, 4'h0, 4'h0, 1'b1, 3'd2, 16'(1 << b));
      check_all("R4");
    end

    // R5: collision, set wins
    step(16'h0008, 4'h2, 4'h0, 1'b1, 3'd0, 16'hFFFF);
    check_all("R5");
    step(16'h0000, 4'h2, 4'h0, 1'b1, 3'd2, 16'hFFFF);
    check_all("R5");

    // R7 / R8: control readback, repeated reads change nothing
    step('0, 4'h0, 4'h0, 1'b1, 3'd1, 16'hC3A5);
    check_all("R7");
    check_all("R8");
    check_all("R8");

    // R9: unused addresses, and writes never set status
    step('0, 4'h0, 4'h0, 1'b1, 3'd5, 16'hFFFF);
    check_all("R9");
    step('0, 4'h0, 4'h0, 1'b1, 3'd7, 16'hFFFF);
    check_all("R9");
    step('0, 4'h0, 4'h0, 1'b1, 3'd0, 16'h0000);
    step('0, 4'h0, 4'h0, 1'b1, 3'd2, 16'h0000);
    check_all("R9");

    // Mixed random traffic against the model
    for (int i = 0; i < 600; i++) begin
      logic [15:0] e;
      logic [3:0]  hi, lo;
      e  = ($urandom % 4 == 0) ? 16'($urandom) : 16'h0;
      hi = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
      lo = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
      step(e, hi, lo, 1'($urandom), 3'($urandom), 16'($urandom));
      check_all("R5");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule